// File: doc/BRIEF.md
# I2C Target Address Decoder

This block is the receive front end of an I2C target. It runs on a fast system clock and oversamples the SCL and SDA lines through a two-flop synchronizer. From the synchronized copies it detects START, repeated START and STOP conditions and shifts in address bytes MSB first. It then decides whether the transfer is meant for it, using either a 7-bit or a 10-bit own address chosen by a mode input.

On a match the block acknowledges by pulling SDA low through an open-drain enable and reports the transfer direction. For writes, it passes every following data byte to the user with a one-cycle valid strobe and acknowledges each one. For reads, it acknowledges the address and then lets SDA go. A non-matching transfer is ignored until the next START or STOP. In 10-bit mode, after a complete write-addressed match, a repeated START followed by only the first address byte with the read flag set selects a read from the same target.

Top module: `i2c_tgt_addr_dec`

## Requirements
- R1: After reset, `sda_pull`, `addressed` and `rx_valid` are 0.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Both are seen on synchronized lines. A STOP clears `addressed` and returns the block to idle.
- R3: With `ten_bit_mode`=0, the first byte after START is {address[6:0], rw}, where rw=0 means write (own address 0x50 written appears as 0xA0). On a match the block ACKs, sets `addressed`=1 and sets `rd_dir` to rw.
- R4: With `ten_bit_mode`=1, the first byte is {5'b11110, address[9:8], rw} and the second byte is address[7:0]. A write match ACKs both bytes and sets `addressed`=1 only after the second byte. A first byte that does not begin with 11110 is not ACKed.
- R5: In 10-bit mode, after a complete write match, a repeated START and one first byte with rw=1 is ACKed and gives `addressed`=1 with `rd_dir`=1. The same byte without a prior write match since the last STOP is NACKed.
- R6: A non-matching address byte is NACKed. The block then ignores the bus (no pull, no `rx_valid`) until the next START or STOP.
- R7: In an addressed write, each data byte appears on `rx_data` MSB first with a one-cycle `rx_valid` pulse after its eighth SCL rising edge, and is ACKed.
- R8: After a read match, the block releases SDA once the address ACK clock ends and does not pull SDA during the following bytes.
- R9: A repeated START in the middle of a transfer restarts address decoding without a STOP. It also clears `addressed` until the new address is decided.
- R10: SDA is only ever pulled low, never driven high. The pull is applied or released only while SCL is low, after the SCL falling edge (ACK is SDA low during the ninth clock).
- R11: When SCL and SDA rise in the same synchronized sample, the block takes a data bit and does not detect a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| ten_bit_mode | input | 1 | 1 selects 10-bit own address, 0 selects 7-bit |
| own_addr | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| addressed | output | 1 | Current transfer is addressed to this target |
| rd_dir | output | 1 | Direction of the addressed transfer, 1 = read |
| rx_data | output | 8 | Last received write data byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` byte |

## Verification
Bit shifting and bus condition detection both look at SDA transitions, and they can fall in the same cycle when SDA changes in the same synchronized sample in which SCL rises. The bench provokes this by sending a data byte with zero setup time, moving SDA and SCL together on every bit including 0-to-1 changes. It judges the outcome through the scoreboard, which must receive the exact byte, and by checking that `addressed` stays high, showing that no false STOP or START was taken. Separately, repeated START is placed directly after a data ACK to show that decoding restarts without passing through idle.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR1,
      PH_ADDR2,
      PH_WDATA,
      PH_READ,
      PH_IGNORE
   } phase_t;

   localparam logic [4:0] TEN_TAG = 5'b11110;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2ct_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in};
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // conditions need SCL high in both samples, so a joint rise is a bit
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_match.sv
module i2ct_match
   import i2ct_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 10
) (
   input  logic              ten_bit,
   input  logic [ADDR_W-1:0] own_addr,
   input  phase_t            phase,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              armed,
   output logic              give_ack,
   output phase_t            nxt_phase,
   output logic              hit,
   output logic              hit_rd,
   output logic              arm_set,
   output logic              arm_clr,
   output logic              data_strobe
);
   localparam int SHORT_W = DATA_W - 1;

   logic tag_ok;
   assign tag_ok = (byte_in[DATA_W-1:3] == TEN_TAG) &&
                   (byte_in[2:1] == own_addr[ADDR_W-1:ADDR_W-2]);

   always_comb begin
      give_ack    = 1'b0;
      nxt_phase   = PH_IGNORE;
      hit         = 1'b0;
      hit_rd      = 1'b0;
      arm_set     = 1'b0;
      arm_clr     = 1'b0;
      data_strobe = 1'b0;
      unique case (phase)
         PH_ADDR1: begin
            if (!ten_bit) begin
               if (byte_in[DATA_W-1:1] == own_addr[SHORT_W-1:0]) begin
                  give_ack  = 1'b1;
                  hit       = 1'b1;
                  hit_rd    = byte_in[0];
                  nxt_phase = byte_in[0] ? PH_READ : PH_WDATA;
               end
            end else if (tag_ok) begin
               if (!byte_in[0]) begin
                  give_ack  = 1'b1;
                  nxt_phase = PH_ADDR2;
               end else if (armed) begin
                  give_ack  = 1'b1;
                  hit       = 1'b1;
                  hit_rd    = 1'b1;
                  nxt_phase = PH_READ;
               end else begin
                  arm_clr = 1'b1;
               end
            end else begin
               arm_clr = 1'b1;
            end
         end
         PH_ADDR2: begin
            if (byte_in == own_addr[DATA_W-1:0]) begin
               give_ack  = 1'b1;
               hit       = 1'b1;
               arm_set   = 1'b1;
               nxt_phase = PH_WDATA;
            end else begin
               arm_clr = 1'b1;
            end
         end
         PH_WDATA: begin
            give_ack    = 1'b1;
            data_strobe = 1'b1;
            nxt_phase   = PH_WDATA;
         end
         default: nxt_phase = phase;
      endcase
   end
endmodule

// File: rtl/i2c_tgt_addr_dec.sv
module i2c_tgt_addr_dec
   import i2ct_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ten_bit_mode,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   output logic              addressed,
   output logic              rd_dir,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("i2c_tgt_addr_dec: bus bytes are 8 bits");
      end
      if (ADDR_W != 10) begin : g_bad_addr
         $error("i2c_tgt_addr_dec: own address is 10 bits");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2ct_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({scl_in, sda_in}),
      .q_out ({scl_s, sda_s})
   );

   i2ct_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   phase_t            phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic              ack_pend, in_ack, armed;
   logic [DATA_W-1:0] byte_nx;
   logic              shifting;

   logic   m_ack, m_hit, m_rd, m_arm_set, m_arm_clr, m_strobe;
   phase_t m_nxt;

   assign byte_nx  = {shreg[DATA_W-2:0], sda_s};
   assign shifting = (phase == PH_ADDR1) || (phase == PH_ADDR2) || (phase == PH_WDATA);

   i2ct_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_match (
      .ten_bit     (ten_bit_mode),
      .own_addr    (own_addr),
      .phase       (phase),
      .byte_in     (byte_nx),
      .armed       (armed),
      .give_ack    (m_ack),
      .nxt_phase   (m_nxt),
      .hit         (m_hit),
      .hit_rd      (m_rd),
      .arm_set     (m_arm_set),
      .arm_clr     (m_arm_clr),
      .data_strobe (m_strobe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         ack_pend  <= 1'b0;
         in_ack    <= 1'b0;
         sda_pull  <= 1'b0;
         addressed <= 1'b0;
         rd_dir    <= 1'b0;
         armed     <= 1'b0;
         rx_data   <= '0;
         rx_valid  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (start_det) begin
            phase     <= PH_ADDR1;
            bit_cnt   <= '0;
            ack_pend  <= 1'b0;
            in_ack    <= 1'b0;
            sda_pull  <= 1'b0;
            addressed <= 1'b0;
            rd_dir    <= 1'b0;
         end else if (stop_det) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            ack_pend  <= 1'b0;
            in_ack    <= 1'b0;
            sda_pull  <= 1'b0;
            addressed <= 1'b0;
            rd_dir    <= 1'b0;
            armed     <= 1'b0;
         end else if (in_ack) begin
            if (scl_fall) begin
               sda_pull <= 1'b0;
               in_ack   <= 1'b0;
               bit_cnt  <= '0;
            end
         end else if (ack_pend) begin
            if (scl_fall) begin
               sda_pull <= 1'b1;
               ack_pend <= 1'b0;
               in_ack   <= 1'b1;
            end
         end else if (scl_rise && shifting) begin
            shreg <= byte_nx;
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               phase    <= m_nxt;
               ack_pend <= m_ack;
               if (m_hit) begin
                  addressed <= 1'b1;
                  rd_dir    <= m_rd;
               end
               if (m_arm_set)      armed <= 1'b1;
               else if (m_arm_clr) armed <= 1'b0;
               if (m_strobe) begin
                  rx_data  <= byte_nx;
                  rx_valid <= 1'b1;
               end
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic sda_pull,
   input logic addressed,
   input logic rd_dir,
   input logic rx_valid,
   input logic scl_rise,
   input logic start_det,
   input logic stop_det
);
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R7
   AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(scl_rise)); // R7
   AST_VALID_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (addressed && !rd_dir)); // R6
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!addressed && !sda_pull)); // R9
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!addressed && !sda_pull)); // R2
   AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !scl_in); // R10
endmodule

bind i2c_tgt_addr_dec i2ct_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_in    (scl_in),
   .sda_pull  (sda_pull),
   .addressed (addressed),
   .rd_dir    (rd_dir),
   .rx_valid  (rx_valid),
   .scl_rise  (scl_rise),
   .start_det (start_det),
   .stop_det  (stop_det)
);

// File: tb/tb_i2c_tgt_addr_dec.sv
module tb_i2c_tgt_addr_dec;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ten_bit_mode = 1'b0;
   logic [9:0] own_addr = 10'h050;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_line;
   logic       sda_pull, addressed, rd_dir, rx_valid;
   logic [7:0] rx_data;

   int n_tests = 0;
   int n_fail  = 0;
   int pull_viol = 0;
   logic pull_prev = 1'b0;
   logic [7:0] exp_q[$];

   assign sda_line = m_sda & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_tgt_addr_dec dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ten_bit_mode (ten_bit_mode),
      .own_addr     (own_addr),
      .scl_in       (m_scl),
      .sda_in       (sda_line),
      .sda_pull     (sda_pull),
      .addressed    (addressed),
      .rd_dir       (rd_dir),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: pop expected bytes as rx_valid fires
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (exp_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R6 unexpected byte actual=%0h expected=none", rx_data);
         end else begin
            chk("R7 rx byte", rx_data, exp_q.pop_front());
         end
      end
      if (rst_n && (sda_pull != pull_prev) && m_scl) pull_viol++;
      pull_prev = sda_pull;
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit zs, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i];
         if (!zs) wq(Q);
         m_scl = 1'b1; wq(2*Q);
         m_scl = 1'b0; wq(Q);
      end
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      acked = !sda_line;
      wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   // driver: sends a write data byte and queues the expected result
   task automatic send_data(input logic [7:0] b, input bit zs, output bit acked);
      exp_q.push_back(b);
      send_byte(b, zs, acked);
   endtask

   task automatic finish_run();
      chk("R10 pull changed with SCL high", pull_viol, 0);
      chk("R6 scoreboard leftover", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      bit a;
      wq(5);
      chk("R1 sda_pull at reset", sda_pull, 0);
      chk("R1 addressed at reset", addressed, 0);
      chk("R1 rx_valid at reset", rx_valid, 0);
      rst_n = 1'b1;
      wq(Q);

      // 7-bit write, own 0x50 -> 0xA0
      bus_start();
      send_byte(8'hA0, 0, a);      chk("R3 ack 7-bit write", a, 1);
      chk("R3 addressed", addressed, 1);
      chk("R3 rd_dir write", rd_dir, 0);
      send_data(8'h3C, 0, a);      chk("R7 data ack", a, 1);
      send_data(8'hC3, 0, a);      chk("R7 data ack 2", a, 1);
      bus_stop();
      chk("R2 stop clears addressed", addressed, 0);

      // mismatch 0x51
      bus_start();
      send_byte(8'hA2, 0, a);      chk("R6 nack mismatch", a, 0);
      chk("R6 not addressed", addressed, 0);
      send_byte(8'h00, 0, a);      chk("R6 data ignored", a, 0);
      bus_stop();

      // write, repeated START, read
      bus_start();
      send_byte(8'hA0, 0, a);
      send_data(8'h11, 0, a);
      bus_rstart();
      chk("R9 restart clears addressed", addressed, 0);
      send_byte(8'hA1, 0, a);      chk("R9 ack after restart", a, 1);
      chk("R3 read direction", rd_dir, 1);
      chk("R3 read addressed", addressed, 1);
      send_byte(8'h55, 0, a);      chk("R8 no pull after read ack", a, 0);
      chk("R8 no pull between bytes", sda_pull, 0);
      bus_stop();

      // zero setup: SCL and SDA rise together
      bus_start();
      send_byte(8'hA0, 0, a);
      send_data(8'h5A, 1, a);      chk("R11 zero-setup byte acked", a, 1);
      chk("R11 no false stop", addressed, 1);
      bus_stop();

      // 10-bit mode, own 0x2B7
      ten_bit_mode = 1'b1; own_addr = 10'h2B7; wq(Q);
      bus_start();
      send_byte(8'hF4, 0, a);      chk("R4 first byte ack", a, 1);
      chk("R4 not yet addressed", addressed, 0);
      send_byte(8'hB7, 0, a);      chk("R4 second byte ack", a, 1);
      chk("R4 addressed", addressed, 1);
      send_data(8'h81, 0, a);      chk("R7 10-bit data ack", a, 1);
      bus_rstart();
      send_byte(8'hF5, 0, a);      chk("R5 read first byte ack", a, 1);
      chk("R5 read addressed", addressed, 1);
      chk("R5 read direction", rd_dir, 1);
      bus_stop();

      // read without prior write match
      bus_start();
      send_byte(8'hF5, 0, a);      chk("R5 unarmed read nack", a, 0);
      bus_stop();

      // second byte mismatch
      bus_start();
      send_byte(8'hF4, 0, a);
      send_byte(8'hB6, 0, a);      chk("R6 10-bit low byte nack", a, 0);
      send_byte(8'h77, 0, a);      chk("R6 10-bit data ignored", a, 0);
      bus_stop();

      // 7-bit style byte in 10-bit mode
      bus_start();
      send_byte(8'hA0, 0, a);      chk("R4 non-tag byte nack", a, 0);
      bus_stop();

      wq(Q);
      finish_run();
   end
endmodule